// File: doc/BRIEF.md
# Crossbar Path Reservation Controller

This block is the central control unit of a single-stage, non-blocking N x N crossbar that links compute nodes. A node that wants to send first raises a reservation request that names a destination node and a transfer length in words. The controller arbitrates, records the path, and answers with a one-cycle grant pulse. Only after that reply does the node drive data. While the path is held, the source's data and valid go through the switch to the destination output in the same cycle.

The data path is byte-sliced. Each byte lane has its own switch slice, and one set of routing state steers every slice. Each output port has a word counter that acts for the receiver. When the counter reaches the requested length, the controller returns a one-cycle completion code to the sender and frees both the destination port and the source in that cycle. A request that names its own node or a zero length gets a one-cycle error reply and reserves nothing.

Each output port runs a two-state machine. In `PORT_FREE` the port's round-robin arbiter looks at the eligible requests. The transition **claim** (an arbiter winner exists) moves the port to `PORT_BOUND`, where it latches the source index and the length. In `PORT_BOUND` the transition **finish** (the word that reaches the length is accepted) returns the port to `PORT_FREE`. Otherwise the port stays in its state.

Top module: `xbar_path_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt`, `rej`, `cmpl` and every `dst_valid` are 0 and every `dst_data` lane is zero.
- R2: A request from an idle source to a free destination other than itself, with a nonzero length, produces `gnt[s]` high for exactly the cycle after the request is sampled, and the path is reserved from that cycle on.
- R3: Before the grant reply appears, the destination output shows `dst_valid` low and zero data, even when the source drives valid data.
- R4: While a path s->d is reserved, `dst_data[d]` equals `src_data[s]` on every byte lane in the same cycle (lane l is bits 8l+7:8l of the node's word), and `dst_valid[d]` equals `src_valid[s]`.
- R5: An output port with no reserved path drives zero data with `dst_valid` low.
- R6: A request whose destination equals its own node index, or whose length is 0, gets `rej[s]` high for one cycle. It gets no grant and reserves no path.
- R7: When several sources request one free destination in the same cycle, a round-robin arbiter grants one of them. The search starts at the index one above the last source granted on that port (index 0 after reset). Losers hold their request and are granted in later cycles.
- R8: A request to a destination that is already reserved gets no grant while the path is held, and it is granted in the cycle after the completion code appears.
- R9: After the destination has accepted `len` valid words (cycles with `src_valid` low do not count), `cmpl[s]` is high for exactly the next cycle, and at no time before that.
- R10: In the cycle the completion code is visible, the path is already released: the output is back to zero with valid low, and a request sampled in that cycle can be granted.
- R11: A source that already holds a path gets no second grant, and its data reaches no other output, until its completion code has appeared.
- R12: Reservations between disjoint node pairs made in the same cycle are all granted together and carry data at the same time without interfering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-node reservation request, held until replied |
| req_dst | input | N*IDW | Per-node destination index, IDW bits per node |
| req_len | input | N*LEN_W | Per-node transfer length in words |
| gnt | output | N | One-cycle grant reply per node |
| rej | output | N | One-cycle error reply per node |
| cmpl | output | N | One-cycle completion code returned to the sender |
| src_valid | input | N | Per-node data valid into the switch |
| src_data | input | N*LANES*8 | Per-node data word into the switch, LANES bytes |
| dst_valid | output | N | Per-node data valid out of the switch |
| dst_data | output | N*LANES*8 | Per-node data word out of the switch |

## Verification
The bench walks every ordered pair of the eight nodes with lengths from 1 to 3 and puts an idle gap inside the transfers. A design that counted idle cycles, answered one cycle late, or let data leak through before the grant or after release would fail the per-cycle output checks. Contention cases check the rotating priority: after two grants to sources 1 and 3 on port 5, source 6 must win against source 1, which a fixed-priority arbiter would get wrong. Busy-destination, busy-source, self-target and zero-length requests check that a design does not over-grant, re-grant a held source, or reserve a path for a request it rejects. Four disjoint paths opened at once check that the slices stay independent.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // State of one crossbar output port.
    typedef enum logic [0:0] {
        PORT_FREE  = 1'b0,
        PORT_BOUND = 1'b1
    } port_state_t;

endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic          hit;
    logic [IW-1:0] widx;

    // Search starts at the pointer and wraps around.
    always_comb begin
        win  = '0;
        hit  = 1'b0;
        widx = '0;
        for (int k = 0; k < N; k++) begin
            if (!hit && req[(int'(ptr_q) + k) % N]) begin
                win[(int'(ptr_q) + k) % N] = 1'b1;
                widx = IW'((int'(ptr_q) + k) % N);
                hit  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (hit) begin
            ptr_q <= IW'((int'(widx) + 1) % N);
        end
    end

    a_r7_onehot_win: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    a_r7_win_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (win & ~req) == '0);

endmodule

// File: rtl/xbar_lane_slice.sv
module xbar_lane_slice #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic [N*8-1:0]   in_bytes,
    input  logic [N*IDW-1:0] sel_flat,
    input  logic [N-1:0]     en,
    output logic [N*8-1:0]   out_bytes
);
    // One byte lane of the switch: each output picks one input byte.
    always_comb begin
        out_bytes = '0;
        for (int d = 0; d < N; d++) begin
            if (en[d]) begin
                out_bytes[d*8 +: 8] = in_bytes[int'(sel_flat[d*IDW +: IDW])*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
    import xbar_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDW   = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     cand,
    input  logic [N*LEN_W-1:0] len_all,
    input  logic             word_in,
    output logic             bound,
    output logic [IDW-1:0]   sel,
    output logic [N-1:0]     win,
    output logic             last
);
    port_state_t      state_q, state_d;
    logic [IDW-1:0]   sel_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [N-1:0]     arb_req;
    logic [IDW-1:0]   widx;

    assign arb_req = (state_q == PORT_FREE) ? cand : '0;

    xbar_rr_arb #(.N(N)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (arb_req),
        .win  (win)
    );

    always_comb begin
        widx = '0;
        for (int k = 0; k < N; k++) begin
            if (win[k]) widx = IDW'(k);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_FREE:  if (|win) state_d = PORT_BOUND;
            PORT_BOUND: if (last) state_d = PORT_FREE;
            default:    state_d = PORT_FREE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_FREE;
        else        state_q <= state_d;
    end

    // Path bookkeeping: source index, length, word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else if (state_q == PORT_FREE && |win) begin
            sel_q <= widx;
            len_q <= len_all[int'(widx)*LEN_W +: LEN_W];
            cnt_q <= '0;
        end else if (state_q == PORT_BOUND && word_in) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        bound = (state_q == PORT_BOUND);
        sel   = sel_q;
        last  = (state_q == PORT_BOUND) && word_in && (cnt_q == len_q - LEN_W'(1));
    end

    a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_BOUND) |-> (cnt_q < len_q));

    a_r10_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (state_q == PORT_FREE));

    a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_BOUND && !last) |=> $stable(sel_q));

endmodule

// File: rtl/xbar_path_ctrl.sv
module xbar_path_ctrl #(
    parameter int N     = 8,
    parameter int LANES = 4,
    parameter int LEN_W = 8,
    parameter int IDW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_valid,
    input  logic [N*IDW-1:0]     req_dst,
    input  logic [N*LEN_W-1:0]   req_len,
    output logic [N-1:0]         gnt,
    output logic [N-1:0]         rej,
    output logic [N-1:0]         cmpl,
    input  logic [N-1:0]         src_valid,
    input  logic [N*LANES*8-1:0] src_data,
    output logic [N-1:0]         dst_valid,
    output logic [N*LANES*8-1:0] dst_data
);
    localparam int DW = LANES * 8;

    logic [N-1:0]     src_busy_q, gnt_q, rej_q, cmpl_q;
    logic [N-1:0]     gnt_d, rej_d, cmpl_d;
    logic [N-1:0]     bound, last;
    logic [N*IDW-1:0] sel_flat;
    logic [N-1:0]     cand [N];
    logic [N-1:0]     win  [N];
    logic [N*8-1:0]   lane_in  [LANES];
    logic [N*8-1:0]   lane_out [LANES];

    // Request qualification per destination.
    always_comb begin
        for (int d = 0; d < N; d++) begin
            for (int s = 0; s < N; s++) begin
                cand[d][s] = req_valid[s]
                          && (req_dst[s*IDW +: IDW] == IDW'(d))
                          && (s != d)
                          && (req_len[s*LEN_W +: LEN_W] != '0)
                          && !src_busy_q[s];
            end
        end
    end

    always_comb begin
        for (int s = 0; s < N; s++) begin
            rej_d[s] = req_valid[s]
                    && ((req_dst[s*IDW +: IDW] == IDW'(s))
                        || (req_len[s*LEN_W +: LEN_W] == '0));
        end
    end

    // One controller per output port.
    for (genvar d = 0; d < N; d++) begin : g_port
        xbar_out_port #(.N(N), .IDW(IDW), .LEN_W(LEN_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand   (cand[d]),
            .len_all(req_len),
            .word_in(dst_valid[d]),
            .bound  (bound[d]),
            .sel    (sel_flat[d*IDW +: IDW]),
            .win    (win[d]),
            .last   (last[d])
        );
    end

    // Gather grants and completions per source.
    always_comb begin
        gnt_d  = '0;
        cmpl_d = '0;
        for (int d = 0; d < N; d++) begin
            gnt_d = gnt_d | win[d];
            if (last[d]) cmpl_d[int'(sel_flat[d*IDW +: IDW])] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_busy_q <= '0;
            gnt_q      <= '0;
            rej_q      <= '0;
            cmpl_q     <= '0;
        end else begin
            src_busy_q <= (src_busy_q | gnt_d) & ~cmpl_d;
            gnt_q      <= gnt_d;
            rej_q      <= rej_d;
            cmpl_q     <= cmpl_d;
        end
    end

    always_comb begin
        gnt  = gnt_q;
        rej  = rej_q;
        cmpl = cmpl_q;
        for (int d = 0; d < N; d++) begin
            dst_valid[d] = bound[d] && src_valid[int'(sel_flat[d*IDW +: IDW])];
        end
    end

    // Byte-sliced data path: one slice per lane, common steering.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < N; s++) begin
                lane_in[l][s*8 +: 8] = src_data[s*DW + l*8 +: 8];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xbar_lane_slice #(.N(N), .IDW(IDW)) u_slice (
            .in_bytes (lane_in[l]),
            .sel_flat (sel_flat),
            .en       (bound),
            .out_bytes(lane_out[l])
        );
    end

    always_comb begin
        for (int d = 0; d < N; d++) begin
            for (int l = 0; l < LANES; l++) begin
                dst_data[d*DW + l*8 +: 8] = lane_out[l][d*8 +: 8];
            end
        end
    end

    a_r6_reply_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q & rej_q) == '0);

    for (genvar s = 0; s < N; s++) begin : g_src_chk
        logic [N-1:0] owns;
        always_comb begin
            for (int d = 0; d < N; d++) begin
                owns[d] = bound[d] && (sel_flat[d*IDW +: IDW] == IDW'(s));
            end
        end

        a_r2_busy_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_busy_q[s]) |-> gnt_q[s]);

        a_r9_free_with_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(src_busy_q[s]) |-> cmpl_q[s]);

        a_r9_cmpl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl_q[s] |=> !cmpl_q[s]);

        a_r11_one_path_per_src: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owns) <= 1);
    end

endmodule

// File: tb/xbar_path_ctrl_tb.sv
module xbar_path_ctrl_tb;
    localparam int N     = 8;
    localparam int LANES = 4;
    localparam int LEN_W = 8;
    localparam int IDW   = 3;
    localparam int DW    = LANES * 8;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N-1:0]         req_valid;
    logic [N*IDW-1:0]     req_dst;
    logic [N*LEN_W-1:0]   req_len;
    logic [N-1:0]         gnt, rej, cmpl;
    logic [N-1:0]         src_valid;
    logic [N*DW-1:0]      src_data;
    logic [N-1:0]         dst_valid;
    logic [N*DW-1:0]      dst_data;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbar_path_ctrl #(.N(N), .LANES(LANES), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dst(req_dst), .req_len(req_len),
        .gnt(gnt), .rej(rej), .cmpl(cmpl),
        .src_valid(src_valid), .src_data(src_data),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int s, input int k);
        logic [DW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*8 +: 8] = 8'(s*37 + l*11 + k*5 + 1);
        return r;
    endfunction

    task automatic set_req(input int s, input int d, input int len);
        req_valid[s] = 1'b1;
        req_dst[s*IDW +: IDW] = IDW'(d);
        req_len[s*LEN_W +: LEN_W] = LEN_W'(len);
    endtask

    task automatic drive_word(input int s, input int k);
        src_valid[s] = 1'b1;
        src_data[s*DW +: DW] = pat(s, k);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = '0; req_dst = '0; req_len = '0;
        src_valid = '0; src_data = '0;
        repeat (3) @(negedge clk);
        chk(gnt == 0 && rej == 0 && cmpl == 0, "R1 replies in reset", {gnt, rej, cmpl}, 0);
        chk(dst_valid == 0 && dst_data == 0, "R1 outputs in reset", dst_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt == 0 && rej == 0 && cmpl == 0 && dst_valid == 0, "R1 after reset", {gnt, rej, cmpl, dst_valid}, 0);
    endtask

    task automatic run_pair(input int s, input int d, input int len);
        @(negedge clk);
        set_req(s, d, len);
        drive_word(s, 99);
        #1;
        chk(dst_valid[d] == 1'b0 && dst_data[d*DW +: DW] == '0, "R3 nothing before reply", dst_valid, 0);
        @(negedge clk);
        chk(gnt == N'(1 << s) && rej == 0, "R2 grant reply", gnt, N'(1 << s));
        req_valid[s] = 1'b0;
        src_valid[s] = 1'b0;
        for (int w = 0; w < len; w++) begin
            if (w == 1) begin
                src_valid[s] = 1'b0;
                #1;
                chk(dst_valid[d] == 1'b0, "R4 idle cycle routed", dst_valid[d], 0);
                chk(cmpl == 0, "R9 no early completion on gap", cmpl, 0);
                @(negedge clk);
            end
            drive_word(s, w);
            #1;
            chk(dst_valid == N'(1 << d) && dst_data[d*DW +: DW] == pat(s, w),
                "R4 routed word", dst_data[d*DW +: DW], pat(s, w));
            chk(cmpl == 0, "R9 no early completion", cmpl, 0);
            for (int o = 0; o < N; o++) begin
                if (o != d) chk(dst_data[o*DW +: DW] == '0, "R5 idle output zero", dst_data[o*DW +: DW], 0);
            end
            @(negedge clk);
        end
        chk(cmpl == N'(1 << s), "R9 completion code", cmpl, N'(1 << s));
        #1;
        chk(dst_valid == 0 && dst_data == 0, "R10 released with code", dst_valid, 0);
        src_valid[s] = 1'b0;
        @(negedge clk);
        chk(cmpl == 0, "R9 completion one cycle", cmpl, 0);
    endtask

    task automatic run_self(input int s, input int d, input int len);
        @(negedge clk);
        set_req(s, d, len);
        @(negedge clk);
        chk(rej == N'(1 << s) && gnt == 0, "R6 error reply", {rej, gnt}, {N'(1 << s), N'(0)});
        req_valid[s] = 1'b0;
        @(negedge clk);
        drive_word(s, 7);
        #1;
        chk(rej == 0 && gnt == 0 && dst_valid == 0 && dst_data == 0, "R6 nothing reserved", dst_valid, 0);
        src_valid[s] = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5: no reservations, all sources drive data.
        @(negedge clk);
        for (int s = 0; s < N; s++) drive_word(s, 3);
        #1;
        chk(dst_valid == 0 && dst_data == 0, "R5 no paths all zero", dst_valid, 0);
        src_valid = '0;

        // Sweep over every ordered pair.
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                if (s == d) run_self(s, d, 2);
                else        run_pair(s, d, (s + d) % 3 + 1);
            end
        end
        run_self(2, 3, 0); // R6 zero length

        // R7 round-robin contention, fresh pointers.
        do_reset();
        @(negedge clk);
        set_req(1, 5, 1); set_req(3, 5, 1);
        @(negedge clk);
        chk(gnt == 8'h02, "R7 first winner", gnt, 8'h02);
        req_valid[1] = 1'b0;
        drive_word(1, 0);
        #1;
        chk(dst_valid[5] && dst_data[5*DW +: DW] == pat(1, 0), "R4 contention route", dst_data[5*DW +: DW], pat(1, 0));
        @(negedge clk);
        chk(cmpl == 8'h02 && gnt == 0, "R7 winner done loser waits", {cmpl, gnt}, {8'h02, 8'h00});
        src_valid = '0;
        @(negedge clk);
        chk(gnt == 8'h08, "R7 loser granted later", gnt, 8'h08);
        req_valid[3] = 1'b0;
        drive_word(3, 1);
        @(negedge clk);
        chk(cmpl == 8'h08, "R9 loser completion", cmpl, 8'h08);
        src_valid = '0;
        set_req(1, 5, 1); set_req(6, 5, 1);
        @(negedge clk);
        chk(gnt == 8'h40, "R7 rotated priority", gnt, 8'h40);
        req_valid[6] = 1'b0;
        drive_word(6, 2);
        @(negedge clk);
        chk(cmpl == 8'h40, "R9 rotated completion", cmpl, 8'h40);
        src_valid = '0;
        @(negedge clk);
        chk(gnt == 8'h02, "R7 wrapped grant", gnt, 8'h02);
        req_valid[1] = 1'b0;
        drive_word(1, 3);
        @(negedge clk);
        chk(cmpl == 8'h02, "R9 wrapped completion", cmpl, 8'h02);
        src_valid = '0;

        // R8 busy destination.
        @(negedge clk);
        set_req(0, 4, 2);
        @(negedge clk);
        chk(gnt == 8'h01, "R2 grant for busy test", gnt, 8'h01);
        req_valid[0] = 1'b0;
        set_req(2, 4, 1);
        drive_word(0, 0);
        #1;
        chk(dst_data[4*DW +: DW] == pat(0, 0), "R4 first of two", dst_data[4*DW +: DW], pat(0, 0));
        @(negedge clk);
        chk(gnt == 0, "R8 busy destination no grant", gnt, 0);
        drive_word(0, 1);
        @(negedge clk);
        chk(cmpl == 8'h01 && gnt == 0, "R8 code before waiter grant", {cmpl, gnt}, {8'h01, 8'h00});
        src_valid = '0;
        @(negedge clk);
        chk(gnt == 8'h04, "R10 waiter granted after code", gnt, 8'h04);
        req_valid[2] = 1'b0;
        drive_word(2, 0);
        @(negedge clk);
        chk(cmpl == 8'h04, "R9 waiter completion", cmpl, 8'h04);
        src_valid = '0;

        // R11 busy source.
        @(negedge clk);
        set_req(0, 1, 1);
        @(negedge clk);
        chk(gnt == 8'h01, "R2 grant for source test", gnt, 8'h01);
        set_req(0, 2, 1);
        @(negedge clk);
        chk(gnt == 0, "R11 busy source no grant", gnt, 0);
        drive_word(0, 4);
        #1;
        chk(dst_valid == 8'h02, "R11 data only on own path", dst_valid, 8'h02);
        @(negedge clk);
        chk(cmpl == 8'h01 && gnt == 0, "R11 code first", {cmpl, gnt}, {8'h01, 8'h00});
        src_valid = '0;
        @(negedge clk);
        chk(gnt == 8'h01, "R11 granted after release", gnt, 8'h01);
        req_valid[0] = 1'b0;
        drive_word(0, 5);
        #1;
        chk(dst_valid == 8'h04 && dst_data[2*DW +: DW] == pat(0, 5), "R4 new path routes", dst_valid, 8'h04);
        @(negedge clk);
        chk(cmpl == 8'h01, "R9 second path done", cmpl, 8'h01);
        src_valid = '0;

        // R12 disjoint parallel paths.
        @(negedge clk);
        for (int k = 0; k < 4; k++) set_req(k, 7 - k, 1);
        @(negedge clk);
        chk(gnt == 8'h0F, "R12 all granted together", gnt, 8'h0F);
        req_valid = '0;
        for (int k = 0; k < 4; k++) drive_word(k, 6);
        #1;
        chk(dst_valid == 8'hF0, "R12 parallel valids", dst_valid, 8'hF0);
        for (int k = 0; k < 4; k++) begin
            chk(dst_data[(7 - k)*DW +: DW] == pat(k, 6), "R12 parallel data", dst_data[(7 - k)*DW +: DW], pat(k, 6));
        end
        @(negedge clk);
        chk(cmpl == 8'h0F, "R12 all complete", cmpl, 8'h0F);
        src_valid = '0;
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule